// File: doc/BRIEF.md
# Serial character transmitter with inter-character guard time

This block is the sending half of a USART. Software places one character at a time into a single-entry holding register. As soon as the shifter is free, at a bit-period boundary, the character moves into the shifter. The shifter then drives the serial line with a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. Every bit change happens on a bit-rate enable pulse, so the same logic serves both synchronous and asynchronous operation.

Each character can be followed by an idle gap of a programmable number of bit periods. A multi-drop parity setting lets one character be tagged as an address. After a one-shot command, the next written character goes out with its parity bit set, and all other characters go out with it cleared. Two status outputs report whether the holding register can take a new character and whether the whole transmit path has drained.

Top module: `char_tx`

## Requirements
- R1: Out of reset, txd is 1, tx_rdy is 1 and tx_empty is 1. txd is 1 whenever no frame is being shifted.
- R2: A frame starts with a 0 start bit, followed by the data bits least significant first. cfg_len 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. txd changes only on a clock edge where bit_tick is 1, and each bit lasts one bit period.
- R3: The parity bit follows the data bits. Its value depends on cfg_par: 000 gives even parity (the parity bit makes the count of ones over data and parity even), 001 gives odd parity, 010 forces 0 and 011 forces 1.
- R4: With cfg_par 100 or 101, no parity bit is sent. After the data (and parity) bits come the stop bits, all 1: one stop bit when cfg_stop is 0, two when it is 1.
- R5: When cfg_guard is 0, the next start bit follows the last stop bit directly. When cfg_guard is N > 0, txd is held at 1 for N extra bit periods after the stop bits before the next start bit.
- R6: tx_rdy is 0 from the clock edge after a write until the held character enters the shifter. That transfer happens at the first bit_tick edge where the shifter is idle or is finishing its frame, and at that same edge txd drops to the start bit and tx_rdy returns to 1.
- R7: tx_empty is 1 only when the holding register is empty and the shifter (guard periods included) is idle.
- R8: With cfg_par 110 or 111 (multi-drop), a send_addr pulse makes the next written character go out with parity bit 1. Every other character goes out with parity bit 0.
- R9: A write while tx_rdy is 0 replaces the held character. The frame currently being shifted is not altered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| send_addr | input | 1 | One-shot command: mark the next written character as an address |
| cfg_len | input | 2 | Data length select, 5 + value bits |
| cfg_par | input | 3 | Parity mode |
| cfg_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_guard | input | 8 | Idle bit periods inserted after each character |
| txd | output | 1 | Serial data line, idle high |
| tx_rdy | output | 1 | Holding register is free |
| tx_empty | output | 1 | Holding register and shifter are both empty |

## Verification
The assertions assume that bit_tick is a single-cycle pulse, and that the configuration inputs change only while tx_empty is 1. The design captures the format when a frame starts, so changes in the middle of a frame are not covered. The bench meets these assumptions in three ways. It generates bit_tick itself, as one pulse every four clocks. It changes configuration only after waiting for tx_empty plus several idle bit periods. It holds wr_en and send_addr for exactly one cycle at a time. Serial output is captured once per bit period, and each captured stream is compared with frames that the bench builds from the requirement encodings.

// File: rtl/char_tx_pkg.sv
package char_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int LEN_W   = 2;
  localparam int PAR_W   = 3;
  localparam int GUARD_W = 8;
  localparam int MAX_FRAME = 1 + DATA_W + 1 + 2 + (1 << GUARD_W);
  localparam int POS_W   = $clog2(MAX_FRAME);
  localparam int NB_W    = $clog2(DATA_W + 1);

  function automatic logic [NB_W-1:0] data_bits(input logic [LEN_W-1:0] len);
    return NB_W'(DATA_W - (1 << LEN_W) + 1) + NB_W'(len);
  endfunction

  function automatic logic has_parity(input logic [PAR_W-1:0] par);
    return par[2:1] != 2'b10;
  endfunction

  function automatic logic parity_bit(input logic [DATA_W-1:0] d,
                                      input logic [LEN_W-1:0] len,
                                      input logic [PAR_W-1:0] par,
                                      input logic addr);
    logic x;
    x = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < int'(data_bits(len))) x = x ^ d[i];
    case (par)
      3'b000:         return x;
      3'b001:         return ~x;
      3'b011:         return 1'b1;
      3'b110, 3'b111: return addr;
      default:        return 1'b0;
    endcase
  endfunction

  function automatic logic [POS_W-1:0] frame_len(input logic [LEN_W-1:0] len,
                                                 input logic [PAR_W-1:0] par,
                                                 input logic stop2,
                                                 input logic [GUARD_W-1:0] guard);
    return POS_W'(1) + POS_W'(data_bits(len)) + POS_W'(has_parity(par))
         + (stop2 ? POS_W'(2) : POS_W'(1)) + POS_W'(guard);
  endfunction

  function automatic logic frame_bit(input logic [DATA_W-1:0] d,
                                     input logic [POS_W-1:0] idx,
                                     input logic [NB_W-1:0] nb,
                                     input logic hp,
                                     input logic pb);
    logic [POS_W-1:0] k;
    k = idx - POS_W'(1);
    if (idx == '0) return 1'b0;
    if (idx <= POS_W'(nb)) return d[k[$clog2(DATA_W)-1:0]];
    if (hp && idx == POS_W'(nb) + POS_W'(1)) return pb;
    return 1'b1;
  endfunction
endpackage

// File: rtl/char_tx_hold.sv
module char_tx_hold
  import char_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              send_addr,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data,
  output logic              addr
);
  logic addr_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full         <= 1'b0;
      data         <= '0;
      addr         <= 1'b0;
      addr_pending <= 1'b0;
    end else begin
      if (wr_en) begin
        full <= 1'b1;
        data <= wr_data;
        addr <= addr_pending;
      end else if (take) begin
        full <= 1'b0;
      end
      if (send_addr)  addr_pending <= 1'b1;
      else if (wr_en) addr_pending <= 1'b0;
    end
  end

  // R6: a transfer with no new write frees the holding register
  assert_free_after_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> !full);
  // R9: a write always lands, replacing whatever was held
  assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (full && data == $past(wr_data)));
  // R8: the address mark is consumed by exactly one write
  assert_addr_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !send_addr) |=> !addr_pending);
  assert_addr_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    send_addr |=> addr_pending);
endmodule

// File: rtl/char_tx_shift.sv
module char_tx_shift
  import char_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               hold_full,
  input  logic [DATA_W-1:0]  hold_data,
  input  logic               hold_addr,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [PAR_W-1:0]   cfg_par,
  input  logic               cfg_stop,
  input  logic [GUARD_W-1:0] cfg_guard,
  output logic               take,
  output logic               busy,
  output logic               txd
);
  logic [DATA_W-1:0] sh_data;
  logic [NB_W-1:0]   sh_nb;
  logic              sh_hp;
  logic              sh_pb;
  logic [POS_W-1:0]  sh_len;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  next_pos;
  logic              last;

  assign next_pos = pos + POS_W'(1);
  assign last     = busy && (next_pos == sh_len);
  assign take     = bit_tick && hold_full && (!busy || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_data <= '0;
      sh_nb   <= '0;
      sh_hp   <= 1'b0;
      sh_pb   <= 1'b0;
      sh_len  <= '0;
      pos     <= '0;
      busy    <= 1'b0;
      txd     <= 1'b1;
    end else if (take) begin
      sh_data <= hold_data;
      sh_nb   <= data_bits(cfg_len);
      sh_hp   <= has_parity(cfg_par);
      sh_pb   <= parity_bit(hold_data, cfg_len, cfg_par, hold_addr);
      sh_len  <= frame_len(cfg_len, cfg_par, cfg_stop, cfg_guard);
      pos     <= '0;
      busy    <= 1'b1;
      txd     <= 1'b0;
    end else if (bit_tick && busy) begin
      if (last) begin
        busy <= 1'b0;
        pos  <= '0;
        txd  <= 1'b1;
      end else begin
        pos  <= next_pos;
        txd  <= frame_bit(sh_data, next_pos, sh_nb, sh_hp, sh_pb);
      end
    end
  end

  // R2: the line moves only at bit-period boundaries
  assert_change_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd));
  // R6: a transfer drives the start bit at once
  assert_start_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!txd && busy));
  // R1: line high whenever nothing is shifting
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  // R5: a frame, guard included, ends only on a bit boundary
  assert_end_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_tick));
endmodule

// File: rtl/char_tx.sv
module char_tx
  import char_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               send_addr,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [PAR_W-1:0]   cfg_par,
  input  logic               cfg_stop,
  input  logic [GUARD_W-1:0] cfg_guard,
  output logic               txd,
  output logic               tx_rdy,
  output logic               tx_empty
);
  logic              take;
  logic              busy;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_addr;

  char_tx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .send_addr (send_addr),
    .take      (take),
    .full      (hold_full),
    .data      (hold_data),
    .addr      (hold_addr)
  );

  char_tx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .hold_addr (hold_addr),
    .cfg_len   (cfg_len),
    .cfg_par   (cfg_par),
    .cfg_stop  (cfg_stop),
    .cfg_guard (cfg_guard),
    .take      (take),
    .busy      (busy),
    .txd       (txd)
  );

  assign tx_rdy   = !hold_full;
  assign tx_empty = !hold_full && !busy;

  // R7: drained path implies a free holding register and an idle line
  assert_empty_means_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (tx_rdy && txd));
endmodule

// File: tb/test_char_tx.sv
`timescale 1ns/1ps
module test_char_tx;
  localparam int TDIV = 4;
  localparam int NVEC = 8;
  // {data[21:14], len[13:12], par[11:9], stop[8], guard[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {8'hA5, 2'd3, 3'b000, 1'b0, 8'd0},
    {8'hA5, 2'd3, 3'b001, 1'b1, 8'd0},
    {8'h13, 2'd0, 3'b010, 1'b0, 8'd2},
    {8'h3C, 2'd1, 3'b011, 1'b1, 8'd0},
    {8'h7E, 2'd2, 3'b100, 1'b0, 8'd1},
    {8'hFF, 2'd3, 3'b101, 1'b1, 8'd0},
    {8'h5A, 2'd3, 3'b000, 1'b0, 8'd5},
    {8'h01, 2'd0, 3'b001, 1'b0, 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       send_addr = 1'b0;
  logic [1:0] cfg_len = '0;
  logic [2:0] cfg_par = '0;
  logic       cfg_stop = 1'b0;
  logic [7:0] cfg_guard = '0;
  logic       txd, tx_rdy, tx_empty;

  int checks = 0;
  int fails = 0;
  int div_cnt = 0;
  logic log_bits [0:4095];
  int   log_n = 0;
  logic exp_bits [0:1023];
  int   exp_n = 0;

  char_tx i_char_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_data(wr_data), .send_addr(send_addr), .cfg_len(cfg_len),
    .cfg_par(cfg_par), .cfg_stop(cfg_stop), .cfg_guard(cfg_guard),
    .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
  );

  always #2 clk = ~clk;

  // capture the line once per bit period, then schedule the next tick
  always @(negedge clk) begin
    if (bit_tick && log_n < 4096) begin
      log_bits[log_n] = txd;
      log_n++;
    end
    div_cnt  = (div_cnt + 1) % TDIV;
    bit_tick = (div_cnt == 0) && rst_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic push(input logic b);
    exp_bits[exp_n] = b;
    exp_n++;
  endtask

  task automatic add_frame(input logic [7:0] d, input logic addr);
    int n;
    logic ones;
    n = 5 + int'(cfg_len);
    ones = 1'b0;
    push(1'b0);
    for (int i = 0; i < n; i++) begin
      push(d[i]);
      ones = ones ^ d[i];
    end
    case (cfg_par)
      3'b000: push(ones);
      3'b001: push(!ones);
      3'b010: push(1'b0);
      3'b011: push(1'b1);
      3'b110, 3'b111: push(addr);
      default: ;
    endcase
    push(1'b1);
    if (cfg_stop) push(1'b1);
    for (int i = 0; i < int'(cfg_guard); i++) push(1'b1);
  endtask

  task automatic begin_case();
    log_n = 0;
    exp_n = 0;
  endtask

  task automatic check_stream(input string tag);
    int s, bad, at;
    logic got, want;
    s = -1; bad = 0; at = -1; got = 1'bx; want = 1'bx;
    for (int i = 0; i < log_n; i++)
      if (s < 0 && log_bits[i] == 1'b0) s = i;
    if (s < 0 || s + exp_n > log_n) begin
      bad = 1;
    end else begin
      for (int i = 0; i < exp_n; i++)
        if (log_bits[s+i] !== exp_bits[i]) begin
          if (at < 0) begin at = i; got = log_bits[s+i]; want = exp_bits[i]; end
          bad++;
        end
      for (int i = s + exp_n; i < log_n; i++)
        if (log_bits[i] !== 1'b1) begin
          if (at < 0) begin at = i - s; got = log_bits[i]; want = 1'b1; end
          bad++;
        end
    end
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: bit %0d actual %b expected %b (start %0d, %0d expected bits, %0d captured)",
               tag, at, got, want, s, exp_n, log_n);
    end
  endtask

  task automatic write_now(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic put_char(input logic [7:0] d);
    @(negedge clk);
    while (!tx_rdy) @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_addr();
    @(negedge clk);
    send_addr = 1'b1;
    @(negedge clk);
    send_addr = 1'b0;
  endtask

  task automatic wait_start();
    @(negedge clk);
    while (txd) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_empty) @(negedge clk);
    repeat (TDIV * 4) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [2:0] p, input logic s, input logic [7:0] g);
    cfg_len = l; cfg_par = p; cfg_stop = s; cfg_guard = g;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 txd after reset", 32'(txd), 32'd1);
    chk("R1 tx_rdy after reset", 32'(tx_rdy), 32'd1);
    chk("R1 tx_empty after reset", 32'(tx_empty), 32'd1);

    // vector table: formats, parity modes, stop counts, single-frame guard
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v][13:12], VEC[v][11:9], VEC[v][8], VEC[v][7:0]);
      repeat (TDIV * 2) @(negedge clk);
      begin_case();
      add_frame(VEC[v][21:14], 1'b0);
      put_char(VEC[v][21:14]);
      wait_idle();
      check_stream($sformatf("R2/R3/R4 vector %0d", v));
    end

    // R6/R7: status timing around one transfer
    set_cfg(2'd3, 3'b000, 1'b0, 8'd0);
    begin_case();
    add_frame(8'h3C, 1'b0);
    write_now(8'h3C);
    chk("R6 tx_rdy low after write", 32'(tx_rdy), 32'd0);
    chk("R7 tx_empty low while held", 32'(tx_empty), 32'd0);
    wait_start();
    chk("R6 tx_rdy high at start bit", 32'(tx_rdy), 32'd1);
    chk("R7 tx_empty low while shifting", 32'(tx_empty), 32'd0);
    wait_idle();
    chk("R7 tx_empty high when drained", 32'(tx_empty), 32'd1);
    check_stream("R2 start-aligned frame");

    // R5: back-to-back with guard 3, then with guard 0
    set_cfg(2'd3, 3'b000, 1'b0, 8'd3);
    begin_case();
    add_frame(8'h81, 1'b0);
    add_frame(8'h42, 1'b0);
    put_char(8'h81);
    put_char(8'h42);
    wait_idle();
    check_stream("R5 guard 3 between frames");

    set_cfg(2'd3, 3'b001, 1'b0, 8'd0);
    begin_case();
    add_frame(8'hC3, 1'b0);
    add_frame(8'h18, 1'b0);
    put_char(8'hC3);
    put_char(8'h18);
    wait_idle();
    check_stream("R5 guard 0 back to back");

    // R4: two stop bits, no parity, back to back
    set_cfg(2'd2, 3'b100, 1'b1, 8'd0);
    begin_case();
    add_frame(8'h55, 1'b0);
    add_frame(8'h2A, 1'b0);
    put_char(8'h55);
    put_char(8'h2A);
    wait_idle();
    check_stream("R4 two stops, no parity");

    // R8: multi-drop address marking
    set_cfg(2'd3, 3'b110, 1'b0, 8'd0);
    repeat (TDIV * 2) @(negedge clk);
    begin_case();
    add_frame(8'h55, 1'b1);
    add_frame(8'h0F, 1'b0);
    add_frame(8'hF0, 1'b0);
    pulse_addr();
    put_char(8'h55);
    put_char(8'h0F);
    put_char(8'hF0);
    wait_idle();
    check_stream("R8 one address then data");

    // R8: without a command every character is data
    begin_case();
    add_frame(8'h77, 1'b0);
    put_char(8'h77);
    wait_idle();
    check_stream("R8 no command, parity 0");

    // R9: overwrite of the held character
    set_cfg(2'd3, 3'b000, 1'b0, 8'd0);
    begin_case();
    add_frame(8'h11, 1'b0);
    add_frame(8'h33, 1'b0);
    put_char(8'h11);
    wait_start();
    write_now(8'h22);
    chk("R9 tx_rdy low before overwrite", 32'(tx_rdy), 32'd0);
    write_now(8'h33);
    wait_idle();
    check_stream("R9 overwrite keeps current frame");
    chk("R1 txd idle at end", 32'(txd), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule